// File: doc/BRIEF.md
# Vertical Line Pixel Generator

This block produces the pixel coordinates of a vertical line, one pixel per clock. A request supplies a column, a top row and a length in pixels. The block captures all three when it accepts the request. It then steps the row downward from the top while the column stays fixed. It flags each valid coordinate, and it marks the final pixel with a one-cycle end pulse. A pixel writer behind it, such as a frame-buffer port, consumes the stream.

A down counter loaded with the length decides how long the run lasts. The line length is therefore set at run time rather than fixed by a chain of states. A zero length is legal: the block draws nothing and still gives the end pulse. After a line, the request input must fall before a new line is accepted, so one long request cannot start a second line.

The controller has four named states. `ST_IDLE` waits for `go`. `ST_RUN` emits one pixel per cycle. `ST_EMPTY` gives the end pulse for a zero-length request. `ST_WAIT_LOW` waits for `go` to fall. The transitions are:

- accept: `ST_IDLE` to `ST_RUN`, when `go` is high and the length is nonzero.
- accept-empty: `ST_IDLE` to `ST_EMPTY`, when `go` is high and the length is zero.
- finish: `ST_RUN` to `ST_WAIT_LOW`, on the last pixel.
- skip: `ST_EMPTY` to `ST_WAIT_LOW`, always.
- rearm: `ST_WAIT_LOW` to `ST_IDLE`, when `go` is low.

Synchronous reset returns the controller to `ST_IDLE` from any state.

Top module: `vline_gen`

## Requirements
- R1: While `rst` is sampled high, and on the cycle after it, `pix_vld` and `pix_end` are both low, and the block is idle.
- R2: When idle, a rising edge that samples `go` high captures `col_in`, `row_in` and `len_in`. For a nonzero length, the first pixel appears in the very next cycle: `pix_vld`=1, `pix_col`=captured column and `pix_row`=captured top row.
- R3: For a length of N (1 to 255), `pix_vld` is high for exactly N consecutive cycles. On pixel i (counted from 0), `pix_row` equals (top + i) mod 256 and `pix_col` equals the captured column.
- R4: `pix_end` is high for exactly one cycle per line, the cycle of the final pixel. `pix_vld` is low in the cycle after it.
- R5: A length of 0 never raises `pix_vld`. `pix_end` is high for one cycle, the cycle right after acceptance.
- R6: Changes to `col_in`, `row_in`, `len_in` or `go` while a line is being drawn do not alter that line's coordinates or its length.
- R7: After a line ends, no new line starts while `go` stays high. `pix_vld` and `pix_end` stay low until `go` has been sampled low.
- R8: Once `go` has been sampled low after a line, the block is idle at the next edge, and a following high `go` starts a new line as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Line request; must fall between lines |
| col_in | input | 9 | Column of the line |
| row_in | input | 8 | Top row of the line |
| len_in | input | 8 | Line length in pixels |
| pix_vld | output | 1 | Current coordinate is a pixel to draw |
| pix_end | output | 1 | Final pixel of the line, or completion of an empty request |
| pix_col | output | 9 | Column of the current pixel |
| pix_row | output | 8 | Row of the current pixel |

## Verification
The bench sweeps every length from 0 to 40, plus the full 255-pixel length. It catches an off-by-one counter, which would draw one pixel too many or too few and move the end pulse away from the last pixel. Top rows near 255 check that the row wraps modulo 256 instead of saturating. It scrambles the inputs right after acceptance, which exposes a design that reads live inputs instead of captured ones. It holds `go` high after a line and drops `go` early during a line: a design with a broken rearm would restart on a held request or hang on an early release. A zero length, and a reset in the middle of a line, check that a design does not emit a stray pixel or end pulse.

// File: rtl/vline_pkg.sv
package vline_pkg;

    // Controller states of the line generator
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_EMPTY    = 2'd2,
        ST_WAIT_LOW = 2'd3
    } vline_state_e;

endpackage

// File: rtl/vline_count.sv
// Remaining-pixel down counter
module vline_count #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             dec,
    output logic             load_zero,
    output logic             last
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_len;
        end else if (dec && (remain_q != '0)) begin
            remain_q <= remain_q - ONE;
        end
    end

    assign load_zero = (load_len == '0);
    assign last      = (remain_q == ONE);
endmodule

// File: rtl/vline_coord.sv
// Captured column and running row
module vline_coord #(
    parameter int COL_W = 9,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [COL_W-1:0] col_in,
    input  logic [ROW_W-1:0] row_in,
    output logic [COL_W-1:0] col_q,
    output logic [ROW_W-1:0] row_q
);
    localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= '0;
        end else if (load) begin
            col_q <= col_in;
            row_q <= row_in;
        end else if (step) begin
            row_q <= row_q + ROW_ONE;
        end
    end
endmodule

// File: rtl/vline_ctrl.sv
// Sequencing state machine
module vline_ctrl
    import vline_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic         len_zero,
    input  logic         last,
    output vline_state_e state,
    output logic         load,
    output logic         step,
    output logic         vld,
    output logic         fin
);
    vline_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d = len_zero ? ST_EMPTY : ST_RUN;
                end
            end
            ST_RUN: begin
                if (last) begin
                    state_d = ST_WAIT_LOW;
                end
            end
            ST_EMPTY: begin
                state_d = ST_WAIT_LOW;
            end
            ST_WAIT_LOW: begin
                if (!go) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        vld  = 1'b0;
        fin  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = go;
            end
            ST_RUN: begin
                step = 1'b1;
                vld  = 1'b1;
                fin  = last;
            end
            ST_EMPTY: begin
                fin = 1'b1;
            end
            ST_WAIT_LOW: begin
            end
            default: begin
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/vline_gen.sv
// Vertical line pixel generator, top level
module vline_gen
    import vline_pkg::*;
#(
    parameter int COL_W = 9,
    parameter int ROW_W = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [COL_W-1:0] col_in,
    input  logic [ROW_W-1:0] row_in,
    input  logic [LEN_W-1:0] len_in,
    output logic             pix_vld,
    output logic             pix_end,
    output logic [COL_W-1:0] pix_col,
    output logic [ROW_W-1:0] pix_row
);
    vline_state_e state;
    logic         load, step, len_zero, last;

    vline_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .len_zero (len_zero),
        .last     (last),
        .state    (state),
        .load     (load),
        .step     (step),
        .vld      (pix_vld),
        .fin      (pix_end)
    );

    vline_count #(.LEN_W(LEN_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_len  (len_in),
        .dec       (step),
        .load_zero (len_zero),
        .last      (last)
    );

    vline_coord #(.COL_W(COL_W), .ROW_W(ROW_W)) u_coord (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .col_in (col_in),
        .row_in (row_in),
        .col_q  (pix_col),
        .row_q  (pix_row)
    );
endmodule

// File: rtl/vline_gen_chk.sv
// Property checker attached to vline_gen
module vline_gen_chk #(
    parameter int COL_W = 9,
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input logic             pix_vld,
    input logic             pix_end,
    input logic [COL_W-1:0] pix_col,
    input logic [ROW_W-1:0] pix_row
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!pix_vld && !pix_end)); // R1
    AST_START_NEEDS_GO: assert property (@(posedge clk) disable iff (rst) $rose(pix_vld) |-> $past(go)); // R2
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst) (pix_vld && !pix_end) |=> (pix_vld && pix_row == ROW_W'($past(pix_row) + 1'b1))); // R3
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (rst) (pix_vld && !pix_end) |=> (pix_col == $past(pix_col))); // R6
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst) pix_end |=> !pix_end); // R4
    AST_END_STOPS: assert property (@(posedge clk) disable iff (rst) pix_end |=> !pix_vld); // R4
    AST_EMPTY_AFTER_GO: assert property (@(posedge clk) disable iff (rst) (pix_end && !pix_vld) |-> ($past(go) && !$past(pix_vld))); // R5
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst) $past(pix_end) |=> !pix_vld); // R7
endmodule

bind vline_gen vline_gen_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .pix_vld (pix_vld),
    .pix_end (pix_end),
    .pix_col (pix_col),
    .pix_row (pix_row)
);

// File: tb/sim_vline_gen.sv
module sim_vline_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go  = 1'b0;
    logic [8:0] col_in = '0;
    logic [7:0] row_in = '0;
    logic [7:0] len_in = '0;
    logic       pix_vld, pix_end;
    logic [8:0] pix_col;
    logic [7:0] pix_row;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    vline_gen u0 (
        .clk(clk), .rst(rst), .go(go),
        .col_in(col_in), .row_in(row_in), .len_in(len_in),
        .pix_vld(pix_vld), .pix_end(pix_end),
        .pix_col(pix_col), .pix_row(pix_row)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_line(input int xv, input int yv, input int hv,
                            input bit drop_early, input int hold);
        @(negedge clk);
        col_in = 9'(xv);
        row_in = 8'(yv);
        len_in = 8'(hv);
        go     = 1'b1;
        @(negedge clk);
        // R6: scramble inputs once the line is accepted
        col_in = 9'(~xv);
        row_in = 8'(yv + 77);
        len_in = 8'(hv ^ 8'h5A);
        if (drop_early) go = 1'b0;
        if (hv == 0) begin
            chk(pix_vld == 1'b0, "R5 vld", int'(pix_vld), 0);
            chk(pix_end == 1'b1, "R5 end", int'(pix_end), 1);
        end else begin
            for (int i = 0; i < hv; i++) begin
                if (i > 0) @(negedge clk);
                chk(pix_vld == 1'b1, "R3 vld", int'(pix_vld), 1);
                chk(int'(pix_row) == ((yv + i) % 256), "R3 row", int'(pix_row), (yv + i) % 256);
                chk(int'(pix_col) == xv, (i == 0) ? "R2 col" : "R6 col", int'(pix_col), xv);
                chk(pix_end == (i == hv - 1), "R4 end", int'(pix_end), int'(i == hv - 1));
            end
        end
        @(negedge clk);
        chk(pix_vld == 1'b0, "R4 vld after end", int'(pix_vld), 0);
        chk(pix_end == 1'b0, "R4 end single", int'(pix_end), 0);
        if (!drop_early) begin
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                chk(!pix_vld && !pix_end, "R7 held go", int'(pix_vld), 0);
            end
            go = 1'b0;
            @(negedge clk);
            chk(!pix_vld && !pix_end, "R8 rearm", int'(pix_vld), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!pix_vld && !pix_end, "R1 reset", int'(pix_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!pix_vld && !pix_end, "R1 after reset", int'(pix_end), 0);

        for (int h = 0; h <= 40; h++) begin
            run_line((h * 11) % 512, (h * 7) % 256, h, (h % 3) == 0, h % 4);
        end
        for (int t = 248; t <= 255; t++) begin
            run_line(511 - t, t, 12, 1'b0, 1);
        end
        run_line(300, 0, 255, 1'b0, 2);
        run_line(0, 1, 1, 1'b1, 0);

        // R1: reset in the middle of a line
        @(negedge clk);
        col_in = 9'd5; row_in = 8'd9; len_in = 8'd20; go = 1'b1;
        repeat (6) @(negedge clk);
        chk(pix_vld == 1'b1, "R3 before reset", int'(pix_vld), 1);
        rst = 1'b1; go = 1'b0;
        @(negedge clk);
        chk(!pix_vld && !pix_end, "R1 mid-line reset", int'(pix_vld), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!pix_vld && !pix_end, "R1 stays idle", int'(pix_vld), 0);
        run_line(17, 30, 5, 1'b0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule